// File: doc/BRIEF.md
# Software Store Unlock Sequencer

This block sits beside a byte-wide static RAM and watches its access stream for a fixed unlock pattern. The pattern is six read cycles to six particular addresses, in a fixed order. When the last of the six reads completes, the block launches a nonvolatile store.

The store runs in two phases. The old nonvolatile contents are erased first, and then the current SRAM contents are programmed. Both phases are modelled here as cycle timers. For the whole store a busy output is held high, and the surrounding memory uses it to lock out all SRAM reads and writes. A single-cycle done pulse marks the moment the SRAM image is copied into the nonvolatile array. Busy drops on that same edge and normal access resumes.

Accesses reach the block as sampled pins: an active-low chip enable, an active-low write enable and the address. The block has no data stream, so every pin is a plain level or pulse with no handshake and no back-pressure. An access cycle ends on the clock where chip enable is first seen high after being low. The output-enable pin plays no part in matching, so it is not an input.

Top module: `store_unlock_seq`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `busy`, `store_start`, `erase_on`, `prog_on` and `store_done` are low, and the matcher stands at step zero.
- R2: Six read cycles to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, raise `store_start`. It rises on the clock edge that sees chip enable high at the end of the sixth cycle.
- R3: An access cycle is a write if `we_n` is sampled low on any clock while `ce_n` is low. A write anywhere in the pattern aborts it, and completing the remaining reads starts no store.
- R4: A read to an address other than the expected next one aborts the pattern, and completing the remaining reads starts no store.
- R5: An aborting read whose address is 0x0E38 counts as the first step of a new pattern.
- R6: From the `store_start` edge, `busy` stays high for exactly ERASE_CYC + PROG_CYC clocks. `erase_on` covers the first ERASE_CYC of them and `prog_on` the remaining PROG_CYC, and the two are never high together.
- R7: `store_done` pulses high for one clock on the edge where `busy` falls, once per store.
- R8: Access cycles that end while `busy` is high are ignored. After a store the matcher is at step zero, so the last five pattern reads alone start no store.
- R9: `store_start` is high for exactly one clock per store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| addr | input | ADDR_W | Sampled access address |
| store_start | output | 1 | One-clock pulse when a store is launched |
| busy | output | 1 | Store in progress; SRAM I/O locked out |
| erase_on | output | 1 | Erase phase active |
| prog_on | output | 1 | Program phase active |
| store_done | output | 1 | One-clock pulse when the SRAM image is committed |

## Verification
The hardest state to reach from the pins is a complete, correctly ordered pattern that is offered while a store is already running. Reaching it shows that the matcher really stays frozen during the lockout.

The bench completes one store and then, straight away, replays all six unlock reads while busy is still high. With the default timings the six reads fit inside the busy window. After busy falls, it sends only the last five reads. The store count must stay unchanged, which proves that no step was credited during the lockout. The restart path of R5 is reached by breaking the pattern with a read of the first address.

// File: rtl/store_unlock_pkg.sv
package store_unlock_pkg;

  localparam int ADDR_W    = 15;
  localparam int NUM_STEPS = 6;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } store_phase_e;

  // Unlock address for each step of the pattern; the order is significant.
  function automatic logic [ADDR_W-1:0] unlock_addr(input int step);
    case (step)
      0:       return 15'h0E38;
      1:       return 15'h31C7;
      2:       return 15'h03E0;
      3:       return 15'h3C1F;
      4:       return 15'h303F;
      default: return 15'h0FC0;
    endcase
  endfunction

endpackage

// File: rtl/sul_cycle_mon.sv
// Turns sampled enable pins into one "cycle ended" event per access,
// tagged with its address and whether it wrote.
module sul_cycle_mon #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          cyc_end,
  output logic          cyc_write,
  output logic [AW-1:0] cyc_addr
);

  logic          ce_n_q;
  logic          wr_seen_q;
  logic [AW-1:0] addr_q;

  // End of an enable-controlled cycle: enable was low, now high.
  assign cyc_end   = !ce_n_q && ce_n;
  assign cyc_write = wr_seen_q;
  assign cyc_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_n_q    <= 1'b1;
      wr_seen_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      ce_n_q <= ce_n;
      if (!ce_n) addr_q <= addr;
      if (cyc_end)
        wr_seen_q <= 1'b0;
      else if (!ce_n && !we_n)
        wr_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sul_matcher.sv
// Step tracker for the unlock pattern.
module sul_matcher
  import store_unlock_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int STEPS = NUM_STEPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_end,
  input  logic          cyc_write,
  input  logic [AW-1:0] cyc_addr,
  input  logic          lock,
  output logic          fire
);

  localparam int SW = $clog2(STEPS + 1);

  logic [SW-1:0]    step_q;
  logic [STEPS-1:0] hit;

  for (genvar g = 0; g < STEPS; g++) begin : g_cmp
    assign hit[g] = (cyc_addr == AW'(unlock_addr(g)));
  end

  logic take;
  logic match_now;
  assign take      = cyc_end && !lock && !cyc_write;
  assign match_now = hit[step_q];
  assign fire      = take && match_now && (step_q == SW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (lock) begin
      step_q <= '0;
    end else if (cyc_end) begin
      if (cyc_write)
        step_q <= '0;
      else if (match_now)
        step_q <= (step_q == SW'(STEPS - 1)) ? '0 : step_q + 1'b1;
      else if (hit[0])
        step_q <= SW'(1);
      else
        step_q <= '0;
    end
  end

endmodule

// File: rtl/sul_timer.sv
// Erase-then-program busy timer.
module sul_timer
  import store_unlock_pkg::*;
#(
  parameter int ERASE_CYC = 16,
  parameter int PROG_CYC  = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic store_start,
  output logic busy,
  output logic erase_on,
  output logic prog_on,
  output logic store_done
);

  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  store_phase_e  phase_q;
  logic [CW-1:0] cnt_q;

  assign busy     = (phase_q != PH_IDLE);
  assign erase_on = (phase_q == PH_ERASE);
  assign prog_on  = (phase_q == PH_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      store_start <= 1'b0;
      store_done  <= 1'b0;
    end else begin
      store_start <= 1'b0;
      store_done  <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q     <= PH_ERASE;
          cnt_q       <= CW'(ERASE_CYC - 1);
          store_start <= 1'b1;
        end
        PH_ERASE: if (cnt_q == '0) begin
          phase_q <= PH_PROG;
          cnt_q   <= CW'(PROG_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_PROG: if (cnt_q == '0) begin
          phase_q    <= PH_IDLE;
          store_done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/store_unlock_seq.sv
module store_unlock_seq
  import store_unlock_pkg::*;
#(
  parameter int ERASE_CYC = 16,
  parameter int PROG_CYC  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              store_start,
  output logic              busy,
  output logic              erase_on,
  output logic              prog_on,
  output logic              store_done
);

  logic              cyc_end;
  logic              cyc_write;
  logic [ADDR_W-1:0] cyc_addr;
  logic              fire;

  sul_cycle_mon #(.AW(ADDR_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .cyc_end(cyc_end), .cyc_write(cyc_write), .cyc_addr(cyc_addr)
  );

  sul_matcher #(.AW(ADDR_W), .STEPS(NUM_STEPS)) u_match (
    .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .lock(busy), .fire(fire)
  );

  sul_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(fire), .store_start(store_start),
    .busy(busy), .erase_on(erase_on), .prog_on(prog_on),
    .store_done(store_done)
  );

endmodule

// File: rtl/store_unlock_seq_chk.sv
module store_unlock_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic store_start,
  input logic busy,
  input logic erase_on,
  input logic prog_on,
  input logic store_done
);

  a_r6_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_on && prog_on));

  a_r6_busy_covers_phases: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (erase_on || prog_on));

  a_r6_start_enters_erase: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> (busy && erase_on));

  a_r6_erase_then_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_on) |-> prog_on);

  a_r7_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> store_done);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> !store_done);

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);

  a_r8_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !store_start);

endmodule

bind store_unlock_seq store_unlock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .store_start(store_start), .busy(busy),
  .erase_on(erase_on), .prog_on(prog_on), .store_done(store_done)
);

// File: tb/store_unlock_seq_test.sv
module store_unlock_seq_test;

  localparam int EC = 16;
  localparam int PC = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic [14:0] addr = '0;
  logic store_start, busy, erase_on, prog_on, store_done;

  int n_tests = 0;
  int n_fail  = 0;
  int c_start = 0, c_busy = 0, c_erase = 0, c_prog = 0, c_done = 0;

  always #5 clk = ~clk;

  store_unlock_seq #(.ERASE_CYC(EC), .PROG_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .store_start(store_start), .busy(busy), .erase_on(erase_on),
    .prog_on(prog_on), .store_done(store_done)
  );

  always @(negedge clk) begin
    if (store_start) c_start++;
    if (busy)        c_busy++;
    if (erase_on)    c_erase++;
    if (prog_on)     c_prog++;
    if (store_done)  c_done++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [14:0] a, input logic wr);
    @(negedge clk);
    ce_n = 1'b0; addr = a; we_n = !wr;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {address, write flag, cumulative store count expected afterwards}
  localparam int NV = 29;
  localparam logic [19:0] VEC [NV] = '{
    {15'h0E38, 1'b0, 4'd0}, {15'h31C7, 1'b0, 4'd0}, {15'h03E0, 1'b0, 4'd0},
    {15'h3C1F, 1'b0, 4'd0}, {15'h303F, 1'b0, 4'd0}, {15'h0FC0, 1'b0, 4'd1},
    {15'h0E38, 1'b0, 4'd1}, {15'h31C7, 1'b0, 4'd1}, {15'h03E0, 1'b1, 4'd1},
    {15'h3C1F, 1'b0, 4'd1}, {15'h303F, 1'b0, 4'd1}, {15'h0FC0, 1'b0, 4'd1},
    {15'h0E38, 1'b0, 4'd1}, {15'h31C7, 1'b0, 4'd1}, {15'h1234, 1'b0, 4'd1},
    {15'h03E0, 1'b0, 4'd1}, {15'h3C1F, 1'b0, 4'd1}, {15'h303F, 1'b0, 4'd1},
    {15'h0FC0, 1'b0, 4'd1},
    {15'h0E38, 1'b0, 4'd1}, {15'h31C7, 1'b0, 4'd1}, {15'h0E38, 1'b0, 4'd1},
    {15'h31C7, 1'b0, 4'd1}, {15'h03E0, 1'b0, 4'd1}, {15'h3C1F, 1'b0, 4'd1},
    {15'h303F, 1'b0, 4'd1}, {15'h0FC0, 1'b0, 4'd2},
    {15'h0E38, 1'b0, 4'd2}, {15'h0E38, 1'b0, 4'd2}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 start in reset", int'(store_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 phases after reset", int'(erase_on) + int'(prog_on) + int'(store_done), 0);

    // Vector walk: R2 full pattern, R3 write abort, R4 mismatch abort, R5 restart
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][19:5], VEC[i][4]);
      check(i < 6 ? "R2 pattern" : i < 12 ? "R3 write abort" :
            i < 19 ? "R4 mismatch abort" : "R5 restart",
            c_start, int'(VEC[i][3:0]));
      if (busy) wait_idle();
    end

    // R6/R7/R9: phase lengths of one store
    begin
      int b0, e0, p0, d0, s0;
      b0 = c_busy; e0 = c_erase; p0 = c_prog; d0 = c_done; s0 = c_start;
      access(15'h0E38, 1'b0); access(15'h31C7, 1'b0); access(15'h03E0, 1'b0);
      access(15'h3C1F, 1'b0); access(15'h303F, 1'b0); access(15'h0FC0, 1'b0);
      wait_idle();
      check("R9 start width", c_start - s0, 1);
      check("R6 busy length", c_busy - b0, EC + PC);
      check("R6 erase length", c_erase - e0, EC);
      check("R6 prog length", c_prog - p0, PC);
      check("R7 done pulses", c_done - d0, 1);
    end

    // R2 timing: start one edge after the final enable rise
    access(15'h0E38, 1'b0); access(15'h31C7, 1'b0); access(15'h03E0, 1'b0);
    access(15'h3C1F, 1'b0); access(15'h303F, 1'b0);
    @(negedge clk); ce_n = 1'b0; addr = 15'h0FC0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    check("R2 no start before edge", int'(store_start), 0);
    @(negedge clk);
    check("R2 start after edge", int'(store_start), 1);
    check("R6 busy with start", int'(busy) + int'(erase_on), 2);

    // R8: full pattern during busy is ignored; then tail alone does nothing
    begin
      int s0;
      s0 = c_start;
      access(15'h0E38, 1'b0); access(15'h31C7, 1'b0); access(15'h03E0, 1'b0);
      access(15'h3C1F, 1'b0); access(15'h303F, 1'b0); access(15'h0FC0, 1'b0);
      check("R8 still busy during replay", int'(busy), 1);
      wait_idle();
      check("R8 no start during busy", c_start - s0, 1);
      access(15'h31C7, 1'b0); access(15'h03E0, 1'b0); access(15'h3C1F, 1'b0);
      access(15'h303F, 1'b0); access(15'h0FC0, 1'b0);
      check("R8 matcher cleared", c_start - s0, 1);
    end

    // R3: write to the expected address also aborts
    begin
      int s0;
      s0 = c_start;
      access(15'h0E38, 1'b0); access(15'h31C7, 1'b1); access(15'h03E0, 1'b0);
      access(15'h3C1F, 1'b0); access(15'h303F, 1'b0); access(15'h0FC0, 1'b0);
      check("R3 write at expected addr", c_start - s0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule